// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two predictors run side by side. The local one keeps a 10-bit outcome history for each branch, selected by instruction-address bits. That history then indexes a table of 3-bit saturating counters. The global one indexes a table of 2-bit counters with a 12-bit path history of recent resolved outcomes. A third table of 2-bit counters, also indexed by the path history, picks which of the two predictions is used.

A fetch stage raises `predict_valid_i` with a PC. One cycle later the block returns the chosen direction together with a snapshot: both component predictions, the local history and the path history used. When the branch resolves, the back end returns that snapshot with the real outcome. The block then trains every table and advances the histories. A mispredicted resolve rebuilds the path history from the snapshot. A context-switch input `clear_i` zeroes every table and the path history in one cycle.

Top module: `tournament_pred`

## Requirements
- R1: `pred_valid_o` is high exactly one cycle after a cycle with `predict_valid_i` high and `clear_i` low. It is low at every other time.
- R2: The local history table has 1024 entries of 10 bits, indexed by `pc_i[11:2]`. `pred_lhist_o` is the entry read in the request cycle.
- R3: The local counters are 1024 entries of 3 bits, indexed by the 10-bit local history. `pred_local_o` is bit 2 of the selected counter.
- R4: The global counters are 4096 entries of 2 bits, indexed by the path history. `pred_global_o` is bit 1 of the selected counter.
- R5: The choice counters are 4096 entries of 2 bits, indexed by the path history. Bit 1 equal to 1 selects the global prediction for `pred_taken_o`; 0 selects the local prediction. When the two agree, `pred_taken_o` equals both.
- R6: On a resolve, the choice counter at `res_ghist_i` changes only if `res_local_i` differs from `res_global_i`. It steps up when the global prediction matched `res_taken_i` and down otherwise.
- R7: All counters saturate: an increment at the maximum and a decrement at zero leave the value unchanged.
- R8: A resolve shifts `res_taken_i` into the local history entry at `res_pc_i[11:2]`, newest outcome at bit 0. It also steps the local counter at `res_lhist_i` and the global counter at `res_ghist_i` toward the outcome.
- R9: `pred_ghist_o` is the path history in the request cycle. A resolve with `res_pred_taken_i == res_taken_i` shifts the outcome in at bit 0. Otherwise the path history becomes `{res_ghist_i[10:0], res_taken_i}`. With no resolve, the path history holds.
- R10: `clear_i` zeroes all tables and the path history, and takes priority over a resolve in the same cycle. A prediction request in that cycle is dropped.
- R11: After reset, every table and the path history are zero and `pred_valid_o` is low.
- R12: A prediction and a resolve in the same cycle: the prediction uses the table and history contents from before the resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Context-switch clear of all state |
| predict_valid_i | input | 1 | Prediction request strobe |
| pc_i | input | 32 | Fetch PC of the branch |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | 32 | PC of the resolving branch |
| res_taken_i | input | 1 | Actual outcome |
| res_pred_taken_i | input | 1 | Snapshot: final prediction |
| res_local_i | input | 1 | Snapshot: local prediction |
| res_global_i | input | 1 | Snapshot: global prediction |
| res_lhist_i | input | 10 | Snapshot: local history used |
| res_ghist_i | input | 12 | Snapshot: path history used |
| pred_valid_o | output | 1 | Prediction valid |
| pred_taken_o | output | 1 | Chosen direction |
| pred_local_o | output | 1 | Local component prediction |
| pred_global_o | output | 1 | Global component prediction |
| pred_lhist_o | output | 10 | Local history snapshot |
| pred_ghist_o | output | 12 | Path history snapshot |

## Verification
The assertions check, on every cycle, the parts that depend only on ports and the path-history register. These are the one-cycle valid timing and its suppression by clear, agreement passing straight to the final direction, the snapshot equal to the previous path history, the mispredict rebuild, hold with no resolve, and zeroing on clear. The counter contents cannot be seen directly. So saturation at both limits, chooser training only on disagreement, local history shifting and same-cycle read-before-update can only be shown by the bench's scenarios. It trains branches, drives opposite outcomes, then reads later predictions against a reference model.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned PC_ALIGN_W = 2;  // 4-byte instructions

  typedef enum logic {
    SEL_LOCAL  = 1'b0,
    SEL_GLOBAL = 1'b1
  } src_sel_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned CTR_W   = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0] mem_q [ENTRIES];
  logic [CTR_W-1:0] cur, nxt;

  assign rd_ctr_o = mem_q[rd_idx_i];
  assign cur      = mem_q[upd_idx_i];

  always_comb begin
    nxt = cur;
    if (upd_up_i) begin
      if (cur != CTR_MAX) nxt = cur + 1'b1;
    end else begin
      if (cur != '0) nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (upd_en_i) begin
      mem_q[upd_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned HIST_W  = 10,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_bit_i
);
  logic [HIST_W-1:0] mem_q [ENTRIES];

  assign rd_hist_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (upd_en_i) begin
      mem_q[upd_idx_i] <= {mem_q[upd_idx_i][HIST_W-2:0], upd_bit_i};
    end
  end
endmodule

// File: rtl/tp_path_hist.sv
module tp_path_hist #(
  parameter int unsigned HIST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              res_en_i,
  input  logic              restore_i,
  input  logic [HIST_W-1:0] snap_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, base;

  // mispredict: rebuild from the checkpoint taken at prediction time
  assign base   = restore_i ? snap_i : hist_q;
  assign hist_o = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (clear_i)  hist_q <= '0;
    else if (res_en_i) hist_q <= {base[HIST_W-2:0], bit_i};
  end
endmodule

// File: rtl/tournament_pred.sv
module tournament_pred #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned LHT_ENTRIES = 1024,
  parameter int unsigned LHIST_W     = 10,
  parameter int unsigned LCTR_W      = 3,
  parameter int unsigned GHIST_W     = 12,
  parameter int unsigned GCTR_W      = 2,
  parameter int unsigned CCTR_W      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               predict_valid_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               res_valid_i,
  input  logic [PC_W-1:0]    res_pc_i,
  input  logic               res_taken_i,
  input  logic               res_pred_taken_i,
  input  logic               res_local_i,
  input  logic               res_global_i,
  input  logic [LHIST_W-1:0] res_lhist_i,
  input  logic [GHIST_W-1:0] res_ghist_i,
  output logic               pred_valid_o,
  output logic               pred_taken_o,
  output logic               pred_local_o,
  output logic               pred_global_o,
  output logic [LHIST_W-1:0] pred_lhist_o,
  output logic [GHIST_W-1:0] pred_ghist_o
);
  import tp_pkg::*;

  localparam int unsigned LHT_IDX_W   = $clog2(LHT_ENTRIES);
  localparam int unsigned LPT_ENTRIES = 1 << LHIST_W;
  localparam int unsigned GPT_ENTRIES = 1 << GHIST_W;
  localparam int unsigned IDX_LO      = PC_ALIGN_W;
  localparam int unsigned IDX_HI      = PC_ALIGN_W + LHT_IDX_W - 1;

  logic [LHT_IDX_W-1:0] req_idx, res_idx;
  logic [LHIST_W-1:0]   lhist_rd;
  logic [LCTR_W-1:0]    lctr_rd;
  logic [GCTR_W-1:0]    gctr_rd;
  logic [CCTR_W-1:0]    cctr_rd;
  logic [GHIST_W-1:0]   ghist_q;
  logic                 loc_dir, glb_dir, fin_dir;
  src_sel_e             sel;
  logic                 req_ok, mispredict, choice_upd;
  logic                 unused_pc;

  assign req_idx   = pc_i[IDX_HI:IDX_LO];
  assign res_idx   = res_pc_i[IDX_HI:IDX_LO];
  assign unused_pc = ^{pc_i[PC_W-1:IDX_HI+1], pc_i[IDX_LO-1:0],
                       res_pc_i[PC_W-1:IDX_HI+1], res_pc_i[IDX_LO-1:0]};

  tp_hist_table #(.ENTRIES(LHT_ENTRIES), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni, .clear_i,
    .rd_idx_i (req_idx),
    .rd_hist_o(lhist_rd),
    .upd_en_i (res_valid_i),
    .upd_idx_i(res_idx),
    .upd_bit_i(res_taken_i)
  );

  tp_ctr_table #(.ENTRIES(LPT_ENTRIES), .CTR_W(LCTR_W)) u_lpt (
    .clk_i, .rst_ni, .clear_i,
    .rd_idx_i (lhist_rd),
    .rd_ctr_o (lctr_rd),
    .upd_en_i (res_valid_i),
    .upd_idx_i(res_lhist_i),
    .upd_up_i (res_taken_i)
  );

  tp_ctr_table #(.ENTRIES(GPT_ENTRIES), .CTR_W(GCTR_W)) u_gpt (
    .clk_i, .rst_ni, .clear_i,
    .rd_idx_i (ghist_q),
    .rd_ctr_o (gctr_rd),
    .upd_en_i (res_valid_i),
    .upd_idx_i(res_ghist_i),
    .upd_up_i (res_taken_i)
  );

  // chooser trains only when the components disagreed
  assign choice_upd = res_valid_i && (res_local_i != res_global_i);

  tp_ctr_table #(.ENTRIES(GPT_ENTRIES), .CTR_W(CCTR_W)) u_cpt (
    .clk_i, .rst_ni, .clear_i,
    .rd_idx_i (ghist_q),
    .rd_ctr_o (cctr_rd),
    .upd_en_i (choice_upd),
    .upd_idx_i(res_ghist_i),
    .upd_up_i (res_global_i == res_taken_i)
  );

  assign mispredict = res_pred_taken_i != res_taken_i;

  tp_path_hist #(.HIST_W(GHIST_W)) u_path (
    .clk_i, .rst_ni, .clear_i,
    .res_en_i (res_valid_i),
    .restore_i(mispredict),
    .snap_i   (res_ghist_i),
    .bit_i    (res_taken_i),
    .hist_o   (ghist_q)
  );

  assign loc_dir = lctr_rd[LCTR_W-1];
  assign glb_dir = gctr_rd[GCTR_W-1];
  assign sel     = src_sel_e'(cctr_rd[CCTR_W-1]);
  assign fin_dir = (sel == SEL_GLOBAL) ? glb_dir : loc_dir;
  assign req_ok  = predict_valid_i && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o  <= 1'b0;
      pred_taken_o  <= 1'b0;
      pred_local_o  <= 1'b0;
      pred_global_o <= 1'b0;
      pred_lhist_o  <= '0;
      pred_ghist_o  <= '0;
    end else begin
      pred_valid_o <= req_ok;
      if (req_ok) begin
        pred_taken_o  <= fin_dir;
        pred_local_o  <= loc_dir;
        pred_global_o <= glb_dir;
        pred_lhist_o  <= lhist_rd;
        pred_ghist_o  <= ghist_q;
      end
    end
  end
endmodule

// File: rtl/tournament_pred_chk.sv
module tournament_pred_chk #(
  parameter int unsigned GHIST_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               predict_valid_i,
  input logic               res_valid_i,
  input logic               res_pred_taken_i,
  input logic               res_taken_i,
  input logic [GHIST_W-1:0] res_ghist_i,
  input logic               pred_valid_o,
  input logic               pred_taken_o,
  input logic               pred_local_o,
  input logic               pred_global_o,
  input logic [GHIST_W-1:0] pred_ghist_o,
  input logic [GHIST_W-1:0] ghist_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  valid_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (pred_valid_o == $past(predict_valid_i && !clear_i)));

  // R5
  agree_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o && (pred_local_o == pred_global_o)) |-> (pred_taken_o == pred_local_o));

  // R9
  snap_ghist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pred_valid_o) |-> (pred_ghist_o == $past(ghist_q)));

  // R9
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !clear_i && (res_pred_taken_i != res_taken_i))
    |=> (ghist_q == {$past(res_ghist_i[GHIST_W-2:0]), $past(res_taken_i)}));

  // R9
  ghist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !clear_i) |=> $stable(ghist_q));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((ghist_q == '0) && !pred_valid_o));
endmodule

bind tournament_pred tournament_pred_chk #(.GHIST_W(GHIST_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clear_i         (clear_i),
  .predict_valid_i (predict_valid_i),
  .res_valid_i     (res_valid_i),
  .res_pred_taken_i(res_pred_taken_i),
  .res_taken_i     (res_taken_i),
  .res_ghist_i     (res_ghist_i),
  .pred_valid_o    (pred_valid_o),
  .pred_taken_o    (pred_taken_o),
  .pred_local_o    (pred_local_o),
  .pred_global_o   (pred_global_o),
  .pred_ghist_o    (pred_ghist_o),
  .ghist_q         (ghist_q)
);

// File: tb/tournament_pred_bench.sv
module tournament_pred_bench;
  typedef struct packed {
    logic        v;
    logic        taken;
    logic        loc;
    logic        glo;
    logic [9:0]  lh;
    logic [11:0] gh;
  } pred_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0;
  logic predict_valid_i = 1'b0, res_valid_i = 1'b0;
  logic [31:0] pc_i = '0, res_pc_i = '0;
  logic res_taken_i = 1'b0, res_pred_taken_i = 1'b0, res_local_i = 1'b0, res_global_i = 1'b0;
  logic [9:0]  res_lhist_i = '0;
  logic [11:0] res_ghist_i = '0;
  logic pred_valid_o, pred_taken_o, pred_local_o, pred_global_o;
  logic [9:0]  pred_lhist_o;
  logic [11:0] pred_ghist_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  tournament_pred u_tournament_pred (.*);

  int errors = 0, checks = 0;
  pred_t exp_q[$];
  pred_t last;
  pred_t zs = '0;

  // reference model
  logic [9:0]  m_lht [1024];
  logic [2:0]  m_lpt [1024];
  logic [1:0]  m_gpt [4096];
  logic [1:0]  m_cpt [4096];
  logic [11:0] m_gh;

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lpt[i] = '0; end
    for (int i = 0; i < 4096; i++) begin m_gpt[i] = '0; m_cpt[i] = '0; end
    m_gh = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit pv, input logic [31:0] pc, input bit rv, input logic [31:0] rpc,
                      input bit rt, input pred_t s, input bit fl, output pred_t e);
    @(negedge clk_i);
    predict_valid_i = pv; pc_i = pc; clear_i = fl;
    res_valid_i = rv; res_pc_i = rpc; res_taken_i = rt;
    res_pred_taken_i = s.taken; res_local_i = s.loc; res_global_i = s.glo;
    res_lhist_i = s.lh; res_ghist_i = s.gh;
    e = '0;
    e.v = pv && !fl;
    if (e.v) begin  // R12: read before this cycle's resolve
      e.lh    = m_lht[pc[11:2]];
      e.loc   = m_lpt[e.lh][2];
      e.gh    = m_gh;
      e.glo   = m_gpt[m_gh][1];
      e.taken = m_cpt[m_gh][1] ? e.glo : e.loc;
    end
    exp_q.push_back(e);
    if (fl) model_clear();
    else if (rv) begin
      if (rt) begin
        if (m_lpt[s.lh] != 3'd7) m_lpt[s.lh]++;
        if (m_gpt[s.gh] != 2'd3) m_gpt[s.gh]++;
      end else begin
        if (m_lpt[s.lh] != 3'd0) m_lpt[s.lh]--;
        if (m_gpt[s.gh] != 2'd0) m_gpt[s.gh]--;
      end
      if (s.loc != s.glo) begin
        if (s.glo == rt) begin if (m_cpt[s.gh] != 2'd3) m_cpt[s.gh]++; end
        else begin if (m_cpt[s.gh] != 2'd0) m_cpt[s.gh]--; end
      end
      m_lht[rpc[11:2]] = {m_lht[rpc[11:2]][8:0], rt};
      m_gh = (s.taken != rt) ? {s.gh[10:0], rt} : {m_gh[10:0], rt};
    end
  endtask

  task automatic pred(input logic [31:0] pc, output pred_t e);
    step(1'b1, pc, 1'b0, '0, 1'b0, zs, 1'b0, e);
  endtask
  task automatic res(input logic [31:0] pc, input bit t, input pred_t s);
    pred_t d;
    step(1'b0, '0, 1'b1, pc, t, s, 1'b0, d);
  endtask
  task automatic idle();
    pred_t d;
    step(1'b0, '0, 1'b0, '0, 1'b0, zs, 1'b0, d);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      pred_t e;
      e = exp_q.pop_front();
      chk("R1 valid", {31'd0, pred_valid_o}, {31'd0, e.v});
      if (e.v && pred_valid_o) begin
        chk("R5 R6 taken", {31'd0, pred_taken_o}, {31'd0, e.taken});
        chk("R3 R7 local", {31'd0, pred_local_o}, {31'd0, e.loc});
        chk("R4 global", {31'd0, pred_global_o}, {31'd0, e.glo});
        chk("R2 R8 lhist", {22'd0, pred_lhist_o}, {22'd0, e.lh});
        chk("R9 ghist", {20'd0, pred_ghist_o}, {20'd0, e.gh});
        last = {pred_valid_o, pred_taken_o, pred_local_o, pred_global_o, pred_lhist_o, pred_ghist_o};
      end
    end
  end

  initial begin
    pred_t p, p2, s;
    model_clear();
    repeat (3) @(negedge clk_i);
    chk("R11 reset valid", {31'd0, pred_valid_o}, 32'd0);
    rst_ni = 1'b1;

    // R11: first prediction from cleared state
    pred(32'h100, p); idle();
    chk("R11 reset snapshot", {20'd0, last.taken, last.loc, last.glo, last.lh}, 32'd0);

    // training, always-taken branches
    for (int i = 0; i < 20; i++) begin pred(32'h100, p); res(32'h100, 1'b1, p); end
    for (int i = 0; i < 20; i++) begin pred(32'h200, p); res(32'h200, 1'b1, p); end

    // R7 upper saturation: counter at history 3FF stays at max, one decrement keeps MSB
    pred(32'h100, p); res(32'h100, 1'b0, p);
    pred(32'h200, p); idle();
    chk("R7 upper saturation", {31'd0, last.loc}, 32'd1);

    // alternating pattern exercises mispredicts and chooser
    for (int i = 0; i < 30; i++) begin pred(32'h400, p); res(32'h400, i[0], p); end

    // R12: overlapping predictions, resolve concurrent with predict, out-of-order mispredict
    pred(32'h800, p); pred(32'h804, p2);
    step(1'b1, 32'h808, 1'b1, 32'h800, ~p.taken, p, 1'b0, s);
    res(32'h804, p2.taken, p2);
    idle();

    // R10: clear with predict and resolve in the same cycle
    step(1'b1, 32'h100, 1'b1, 32'h100, 1'b1, p, 1'b1, s);
    pred(32'h100, p); idle();
    chk("R10 clear ghist", {20'd0, last.gh}, 32'd0);
    chk("R10 clear lhist", {22'd0, last.lh}, 32'd0);

    // R7 lower saturation
    res(32'h300, 1'b0, zs);
    pred(32'h300, p); idle();
    chk("R7 lower saturation", {31'd0, last.loc}, 32'd0);

    // R8 local history shift, newest at bit 0
    res(32'h500, 1'b1, zs); res(32'h500, 1'b0, zs); res(32'h500, 1'b1, zs);
    pred(32'h500, p); idle();
    chk("R8 lhist shift", {22'd0, last.lh}, 32'h5);

    // R9 mispredict restore
    s = zs; s.taken = 1'b1; s.gh = 12'h0F0;
    res(32'h504, 1'b0, s);
    pred(32'h508, p); idle();
    chk("R9 restore", {20'd0, last.gh}, 32'h1E0);

    // R6 chooser trains toward correct global only on disagreement
    s = zs; s.glo = 1'b1; s.gh = 12'hFFF; s.lh = 10'h155;
    res(32'h600, 1'b1, s);
    pred(32'h600, p); idle();
    chk("R6 chooser below threshold", {31'd0, last.taken}, 32'd0);
    res(32'h600, 1'b1, s);
    pred(32'h604, p); idle();
    chk("R6 chooser picks global", {31'd0, last.taken}, 32'd1);
    chk("R6 local still not taken", {31'd0, last.loc}, 32'd0);

    repeat (3) idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule